// File: doc/BRIEF.md
# SPI Memory-Slave Request Deserializer

This block is the receive half of an SPI slave that stands in for a small serial memory. It watches chip select, serial clock and the host's data line, all sampled into the system clock domain. Each transaction is cut into items, and each item leaves on a valid/ready stream as a 32-bit word for a local memory agent. The first item is the command byte. Next comes a word-aligned pointer built from the upper address bits under a fixed tag. The two byte-offset bits of the address follow as a word of their own. Every complete data byte after that becomes one word.

SPI mode 0 is assumed. Chip select is active low and each bit is taken on a rising serial clock edge, most significant bit first. Raising chip select ends the transaction at once and throws away any partly received byte. The output stage holds one word. If a new word completes while that word is still waiting for the consumer, the new word is lost and a sticky overflow flag is raised.

Top module: `spi_req_deser`

## Requirements
- R1: After reset, out_valid is 0 and overflow is 0.
- R2: The first 8 bits after chip select falls, taken MSB first on rising SCK edges, leave as the first word with the command byte in bits 7:0 and zeros above.
- R3: The next 14 bits are address bits 15:2. They leave as the second word, laid out as {ADDR_TAG (16 bits, default 0x2003), address[15:2], 2'b00}.
- R4: The next 2 bits are address bits 1:0. They leave as the third word, with those bits in bits 1:0 and zeros above.
- R5: Each further group of 8 bits leaves as one word, with the byte in bits 7:0 and zeros above. This repeats for as long as chip select stays low.
- R6: SCK edges while chip select is high produce no word.
- R7: Raising chip select discards a partial byte. The next transaction starts again with the command byte.
- R8: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data stays unchanged.
- R9: A word that completes while an unaccepted word is held is dropped and overflow is set. Overflow then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host (asynchronous) |
| spi_cs_n | input | 1 | Chip select from the host, active low (asynchronous) |
| spi_mosi | input | 1 | Serial data from the host (asynchronous) |
| out_valid | output | 1 | Output word is present |
| out_ready | input | 1 | Consumer accepts the word this cycle |
| out_data | output | 32 | Output word |
| overflow | output | 1 | Sticky flag: a word was dropped |

## Verification
The assertions assume that the serial clock is slow compared with the system clock. Each SCK level must last several system cycles, so that every synchronized edge is seen exactly once. They also assume that MOSI is steady around each rising SCK edge and that chip select changes only while SCK is low. The bench keeps to these limits. It holds each SCK phase for four system clock periods, changes MOSI only while SCK is low, and leaves guard time on both sides of every chip-select change.

// File: rtl/spi_deser_pkg.sv
package spi_deser_pkg;

  // Position of the receiver inside one chip-select frame.
  typedef enum logic [1:0] {
    PH_CMD     = 2'd0,
    PH_ADDR_HI = 2'd1,
    PH_ADDR_LO = 2'd2,
    PH_DATA    = 2'd3
  } frame_phase_t;

endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= RST_VAL;
          else        stage[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= RST_VAL;
          else        stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_deser_pkg::*;
#(
  parameter int CMD_BITS  = 8,
  parameter int ADDR_BITS = 16,
  parameter int DATA_BITS = 8,
  parameter int WORD_W    = 32,
  parameter int TAG_W     = 16,
  parameter logic [TAG_W-1:0] ADDR_TAG = 16'h2003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              sck_rise,
  input  logic              mosi,
  output logic              word_done,
  output logic [WORD_W-1:0] word_data,
  output frame_phase_t      phase
);
  localparam int HI_BITS = ADDR_BITS - 2;
  localparam int SR_W    = (CMD_BITS > ADDR_BITS) ?
                           ((CMD_BITS > DATA_BITS) ? CMD_BITS : DATA_BITS) :
                           ((ADDR_BITS > DATA_BITS) ? ADDR_BITS : DATA_BITS);
  localparam int CNT_W   = $clog2(SR_W + 1);

  logic [SR_W-1:0]  sr, sr_nx;
  logic [CNT_W-1:0] cnt, limit;
  logic             last;
  frame_phase_t     phase_nx;

  function automatic logic [WORD_W-1:0] cmd_word(input logic [SR_W-1:0] s);
    return WORD_W'(s[CMD_BITS-1:0]);
  endfunction

  function automatic logic [WORD_W-1:0] ptr_word(input logic [SR_W-1:0] s);
    return {ADDR_TAG, s[HI_BITS-1:0], 2'b00};
  endfunction

  function automatic logic [WORD_W-1:0] off_word(input logic [SR_W-1:0] s);
    return WORD_W'(s[1:0]);
  endfunction

  function automatic logic [WORD_W-1:0] byte_word(input logic [SR_W-1:0] s);
    return WORD_W'(s[DATA_BITS-1:0]);
  endfunction

  always_comb begin
    sr_nx = {sr[SR_W-2:0], mosi};
    unique case (phase)
      PH_CMD:     begin limit = CNT_W'(CMD_BITS);  phase_nx = PH_ADDR_HI; word_data = cmd_word(sr_nx);  end
      PH_ADDR_HI: begin limit = CNT_W'(HI_BITS);   phase_nx = PH_ADDR_LO; word_data = ptr_word(sr_nx);  end
      PH_ADDR_LO: begin limit = CNT_W'(2);         phase_nx = PH_DATA;    word_data = off_word(sr_nx);  end
      default:    begin limit = CNT_W'(DATA_BITS); phase_nx = PH_DATA;    word_data = byte_word(sr_nx); end
    endcase
    last      = (cnt == limit - CNT_W'(1));
    word_done = cs_act && sck_rise && last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      cnt   <= '0;
      phase <= PH_CMD;
    end else if (!cs_act) begin
      sr    <= '0;
      cnt   <= '0;
      phase <= PH_CMD;
    end else if (sck_rise) begin
      if (last) begin
        sr    <= '0;
        cnt   <= '0;
        phase <= phase_nx;
      end else begin
        sr    <= sr_nx;
        cnt   <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/spi_out_slot.sv
module spi_out_slot #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_done,
  input  logic [WORD_W-1:0] word_data,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              overflow
);
  logic slot_free;
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      overflow  <= 1'b0;
    end else begin
      if (word_done && slot_free) begin
        out_valid <= 1'b1;
        out_data  <= word_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (word_done && !slot_free) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_req_deser.sv
module spi_req_deser
  import spi_deser_pkg::*;
#(
  parameter int CMD_BITS    = 8,
  parameter int ADDR_BITS   = 16,
  parameter int DATA_BITS   = 8,
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [WORD_W-ADDR_BITS-1:0] ADDR_TAG = 16'h2003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              overflow
);
  localparam int TAG_W = WORD_W - ADDR_BITS;

  logic [2:0]        pins_s;
  logic              sck_s, cs_n_s, mosi_s, sck_prev;
  logic              sck_rise, cs_act, word_done;
  logic [WORD_W-1:0] word_data;
  frame_phase_t      phase;

  spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sck, spi_cs_n, spi_mosi}), .q(pins_s)
  );
  assign sck_s  = pins_s[2];
  assign cs_n_s = pins_s[1];
  assign mosi_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev <= 1'b0;
    else        sck_prev <= sck_s;
  end
  assign sck_rise = sck_s && !sck_prev;
  assign cs_act   = !cs_n_s;

  spi_frame_seq #(
    .CMD_BITS(CMD_BITS), .ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS),
    .WORD_W(WORD_W), .TAG_W(TAG_W), .ADDR_TAG(ADDR_TAG)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .sck_rise(sck_rise),
    .mosi(mosi_s), .word_done(word_done), .word_data(word_data), .phase(phase)
  );

  spi_out_slot #(.WORD_W(WORD_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .word_done(word_done), .word_data(word_data),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .overflow(overflow)
  );
endmodule

// File: rtl/spi_req_deser_chk.sv
module spi_req_deser_chk
  import spi_deser_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              overflow,
  input logic              word_done,
  input logic              cs_act,
  input frame_phase_t      phase
);
  // R8
  hold_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R9
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(out_valid && !out_ready));

  // R8
  valid_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(word_done));

  // R7
  frame_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (phase == PH_CMD));
endmodule

bind spi_req_deser spi_req_deser_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .overflow(overflow), .word_done(word_done),
  .cs_act(cs_act), .phase(phase)
);

// File: tb/sim_spi_req_deser.sv
`timescale 1ns/1ps
module sim_spi_req_deser;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, ready = 1'b1;
  logic        valid, ovf;
  logic [31:0] data;
  logic [31:0] got[$];
  int          checks = 0, fails = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  spi_req_deser u0 (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .out_valid(valid), .out_ready(ready), .out_data(data), .overflow(ovf)
  );

  always @(negedge clk) if (valid && ready) got.push_back(data);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cmp_q(string req, logic [31:0] e[$]);
    chk({req, " word count"}, 32'(got.size()), 32'(e.size()));
    foreach (e[i]) if (i < got.size()) chk(req, got[i], e[i]);
    got.delete();
  endtask

  task automatic bit_out(logic b);
    mosi = b; #20 sck = 1'b1; #20 sck = 1'b0;
  endtask

  task automatic send(logic [15:0] v, int n);
    for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
  endtask

  task automatic cs_low();  cs_n = 1'b0; #40; endtask
  task automatic cs_high(); #40 cs_n = 1'b1; #100; @(negedge clk); endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 valid", 32'(valid), 0);
    chk("R1 overflow", 32'(ovf), 0);
  endtask

  task automatic t_read();
    cs_low(); send(16'h03, 8); send(16'hABCD, 16); cs_high();
    cmp_q("R2 R3 R4 read", '{32'h03, 32'h2003ABCC, 32'h1});
  endtask

  task automatic t_write();
    cs_low(); send(16'h02, 8); send(16'h1236, 16);
    send(16'hA5, 8); send(16'h3C, 8); send(16'hFF, 8); cs_high();
    cmp_q("R5 write", '{32'h02, 32'h20031234, 32'h2, 32'hA5, 32'h3C, 32'hFF});
  endtask

  task automatic t_cs_idle();
    send(16'hFFFF, 16); #100; @(negedge clk);
    cmp_q("R6 idle", '{});
  endtask

  task automatic t_abort();
    cs_low(); send(16'h02, 8); send(16'h0000, 16); send(16'h15, 5); cs_high();
    cs_low(); send(16'h0B, 8); send(16'hFFFF, 16); cs_high();
    cmp_q("R7 abort", '{32'h02, 32'h20030000, 32'h0, 32'h0B, 32'h2003FFFC, 32'h3});
  endtask

  task automatic t_hold();
    ready = 1'b0;
    cs_low(); send(16'h9C, 8); cs_high();
    chk("R8 valid held", 32'(valid), 1);
    chk("R8 data held", data, 32'h9C);
    #200; @(negedge clk);
    chk("R8 still held", data, 32'h9C);
    ready = 1'b1; #20; @(negedge clk);
    chk("R8 released", 32'(valid), 0);
    cmp_q("R8 accepted", '{32'h9C});
    chk("R8 no overflow", 32'(ovf), 0);
  endtask

  task automatic t_ovf();
    ready = 1'b0;
    cs_low(); send(16'h11, 8); send(16'h4444, 16); cs_high();
    chk("R9 overflow set", 32'(ovf), 1);
    ready = 1'b1; #20; @(negedge clk);
    cmp_q("R9 dropped", '{32'h11});
    cs_low(); send(16'h05, 8); cs_high();
    chk("R9 sticky", 32'(ovf), 1);
    cmp_q("R9 after", '{32'h05});
    rst_n = 1'b0; #20; rst_n = 1'b1; @(negedge clk);
    chk("R9 reset clears", 32'(ovf), 0);
  endtask

  initial begin
    #50 rst_n = 1'b1;
    #20;
    t_reset();
    t_read();
    t_write();
    t_cs_idle();
    t_abort();
    t_hold();
    t_ovf();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin #500000; end
    join_any
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule